// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a bank of general-purpose pins grouped into ports (two ports of eight pins by default) and raises an interrupt request when a pin configured as an input no longer matches the level last captured for it. Each port keeps a snapshot of its pin levels. Software reads a port's input register to refresh that snapshot. The request clears by itself as soon as every differing input pin goes back to its captured level. It also clears when the ports involved are read.

The interrupt leaves the block as a pull-low enable for an open-drain line. When `irq_pull_o` is high the pad driver pulls the shared line low. When it is low the line is released, so the block never drives the line high. Pin levels pass through a synchronizer before the comparison. After reset the snapshot is primed from the synchronized pins, so the interrupt starts out released.

Top module: `gpio_chg_irq`

## Requirements
- R1: After reset `irq_pull_o` is 0. During the SYNC_STAGES cycles after reset the snapshot loads the synchronized pin levels, so with steady pins `snap_o` equals the pins and no interrupt follows.
- R2: A pin change reaches the comparison SYNC_STAGES rising edges after it is sampled. `irq_pull_o` follows one edge after that, so it stays 0 for SYNC_STAGES edges and rises on edge SYNC_STAGES+1.
- R3: `irq_pull_o` is 1 whenever, one cycle earlier, some pin with its direction bit at 1 (input) differed from its snapshot bit.
- R4: A pin with its direction bit at 0 (output) never causes or holds the interrupt. If every direction bit is 0, `irq_pull_o` is 0 on the next cycle.
- R5: When every differing input pin returns to its snapshot level, `irq_pull_o` drops without any read, SYNC_STAGES+1 edges after the return.
- R6: A one-cycle pulse on `port_rd_i[p]` recaptures only port p's snapshot (pins p*PORT_W to p*PORT_W+PORT_W-1, visible on `snap_o`). A pending change on another port stays pending. Two edges after all ports are read, `irq_pull_o` is 0.
- R7: Changing a pin's direction bit from 0 to 1 while its level disagrees with its snapshot raises `irq_pull_o` one edge later.
- R8: If a read strobe and the arrival of a pin change at the comparison fall on the same edge, the snapshot takes the new level, and no interrupt results from that change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl_i | input | NUM_PORTS*PORT_W | Raw pin levels, port p in bits p*PORT_W upward |
| pin_is_in_i | input | NUM_PORTS*PORT_W | Direction per pin: 1 input, 0 output |
| port_rd_i | input | NUM_PORTS | Per-port read strobe of the input register |
| snap_o | output | NUM_PORTS*PORT_W | Captured snapshot (input register read data) |
| irq_pull_o | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
The bench builds the block with two ports of eight pins and a three-stage synchronizer. The deeper synchronizer separates the stage that feeds the snapshot on a read from the stage that feeds the comparison, which makes the same-edge capture case observable. Two ports are enough to show that a read of one port leaves the other port's pending change in place. Directed phases cover each timing edge, and then randomized pin, direction and strobe traffic is checked against the behavioural model on every clock.

// File: rtl/gcirq_pkg.sv
package gcirq_pkg;

  typedef enum logic {
    PIN_OUT = 1'b0,
    PIN_IN  = 1'b1
  } pin_dir_e;

  // width of a down-counter that must hold the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/gcirq_sync.sv
module gcirq_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q_pre,
  output logic [W-1:0] q_last
);

  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  // the stage that moves into the last stage on the next edge
  assign q_pre  = stg[STAGES-2];
  assign q_last = stg[STAGES-1];

endmodule

// File: rtl/gcirq_port_snap.sv
module gcirq_port_snap #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prime_i,
  input  logic          rd_i,
  input  logic [PW-1:0] lvl_pre_i,
  input  logic [PW-1:0] lvl_i,
  input  logic [PW-1:0] dir_i,
  output logic [PW-1:0] snap_o,
  output logic          mis_o
);

  function automatic logic port_differs(input logic [PW-1:0] lvl,
                                        input logic [PW-1:0] snap,
                                        input logic [PW-1:0] dir);
    return |(dir & (lvl ^ snap));
  endfunction

  logic load;
  assign load = prime_i | rd_i;

  // capture the level that is about to reach the comparison stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_o <= '0;
    else if (load) snap_o <= lvl_pre_i;
  end

  assign mis_o = port_differs(lvl_i, snap_o, dir_i);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(snap_o));

  assert_capture_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (snap_o == lvl_i));

endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
  import gcirq_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_lvl_i,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_is_in_i,
  input  logic [NUM_PORTS-1:0]        port_rd_i,
  output logic [NUM_PORTS*PORT_W-1:0] snap_o,
  output logic                        irq_pull_o
);

  localparam int W  = NUM_PORTS * PORT_W;
  localparam int CW = cnt_width(SYNC_STAGES);

  logic [W-1:0]         lvl_pre, lvl_sync;
  logic [NUM_PORTS-1:0] port_mis;
  logic [CW-1:0]        prime_cnt;
  logic                 priming;
  logic                 req_now;

  gcirq_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (pin_lvl_i),
    .q_pre  (lvl_pre),
    .q_last (lvl_sync)
  );

  // snapshot follows the pipeline until reset values have flushed out
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prime_cnt <= CW'(SYNC_STAGES);
    else if (priming) prime_cnt <= prime_cnt - 1'b1;
  end
  assign priming = (prime_cnt != '0);

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      gcirq_port_snap #(.PW(PORT_W)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .prime_i   (priming),
        .rd_i      (port_rd_i[p]),
        .lvl_pre_i (lvl_pre[p*PORT_W +: PORT_W]),
        .lvl_i     (lvl_sync[p*PORT_W +: PORT_W]),
        .dir_i     (pin_is_in_i[p*PORT_W +: PORT_W]),
        .snap_o    (snap_o[p*PORT_W +: PORT_W]),
        .mis_o     (port_mis[p])
      );
    end
  endgenerate

  assign req_now = (|port_mis) & ~priming;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_pull_o <= 1'b0;
    else        irq_pull_o <= req_now;
  end

  assert_quiet_prime_R1: assert property (@(posedge clk) disable iff (!rst_n)
    priming |=> !irq_pull_o);

  assert_out_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_is_in_i == '0) |=> !irq_pull_o);

  assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull_o) |-> $past(|pin_is_in_i));

  assert_read_all_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&port_rd_i) |-> ##2 !irq_pull_o);

endmodule

// File: tb/gpio_chg_irq_bench.sv
`timescale 1ns/1ps
module gpio_chg_irq_bench;
  localparam int NP = 2;
  localparam int PW = 8;
  localparam int SS = 3;
  localparam int W  = NP * PW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [W-1:0]  pins, dir;
  logic [NP-1:0] rd;
  logic [W-1:0]  snap;
  logic          irq;

  gpio_chg_irq #(.NUM_PORTS(NP), .PORT_W(PW), .SYNC_STAGES(SS)) u_gpio_chg_irq (
    .clk(clk), .rst_n(rst_n), .pin_lvl_i(pins), .pin_is_in_i(dir),
    .port_rd_i(rd), .snap_o(snap), .irq_pull_o(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1 reset";

  // behavioural model: queue of sampled pin words, index 0 newest
  logic [W-1:0] hq[$];
  logic [W-1:0] m_snap, m_last, m_pre;
  int           m_prime;
  logic         m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq = {};
      for (int i = 0; i < SS; i++) hq.push_back('0);
      m_snap = '0; m_prime = SS; m_irq = 1'b0;
    end else begin
      m_last = hq[SS-1];
      m_pre  = hq[SS-2];
      m_irq  = (m_prime == 0) && ((dir & (m_last ^ m_snap)) != '0);
      if (m_prime > 0) begin
        m_snap = m_pre;
        m_prime--;
      end else begin
        for (int p = 0; p < NP; p++)
          if (rd[p]) m_snap[p*PW +: PW] = m_pre[p*PW +: PW];
      end
      hq.push_front(pins);
      void'(hq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (irq !== m_irq || snap !== m_snap) begin
        n_bad++;
        $display("FAIL %s: irq=%0b snap=%h expected irq=%0b snap=%h",
                 phase, irq, snap, m_irq, m_snap);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    n_cmp++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic expect_snap(input logic [W-1:0] exp, input string tag);
    n_cmp++;
    if (snap !== exp) begin
      n_bad++;
      $display("FAIL %s: snap=%h expected %h", tag, snap, exp);
    end
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pins = 16'hA5C3; dir = '1; rd = '0;
    step(3);
    rst_n = 1'b1;
    step(SS + 3);
    expect_irq(1'b0, "R1 released after reset");
    expect_snap(16'hA5C3, "R1 primed snapshot");

    phase = "R2 sync latency";
    pins = pins ^ 16'h0004;
    step(SS);
    expect_irq(1'b0, "R2 not yet visible");
    phase = "R3 mismatch";
    step(1);
    expect_irq(1'b1, "R3 input mismatch raises");

    phase = "R5 self clear";
    pins = pins ^ 16'h0004;
    step(SS + 1);
    expect_irq(1'b0, "R5 returns to snapshot");

    phase = "R6 per-port read";
    pins = pins ^ 16'h0201;
    step(SS + 1);
    expect_irq(1'b1, "R6 both ports pending");
    rd = 2'b01; step(1); rd = '0;
    step(3);
    expect_irq(1'b1, "R6 port1 still pending");
    expect_snap({8'hA5, pins[7:0]}, "R6 only port0 recaptured");
    rd = 2'b10; step(1); rd = '0;
    step(2);
    expect_irq(1'b0, "R6 cleared after port1 read");
    expect_snap(pins, "R6 both captured");

    phase = "R4 output mask";
    dir = 16'h00FF;
    pins = pins ^ 16'hFF00;
    step(SS + 2);
    expect_irq(1'b0, "R4 output pins ignored");
    expect_snap({pins[15:8] ^ 8'hFF, pins[7:0]}, "R4 snapshot untouched");

    phase = "R7 out to in";
    dir = '1;
    step(2);
    expect_irq(1'b1, "R7 direction change raises");
    rd = 2'b11; step(1); rd = '0;
    step(2);
    expect_irq(1'b0, "R7 read clears");

    phase = "R8 same-edge capture";
    pins = pins ^ 16'h0101;
    step(SS - 1);
    rd = 2'b11; step(1); rd = '0;
    step(3);
    expect_irq(1'b0, "R8 no stuck interrupt");
    expect_snap(pins, "R8 snapshot holds new level");

    phase = "R3 random traffic";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) pins = pins ^ (16'h1 << $urandom_range(0, W - 1));
      if ($urandom_range(0, 9) == 0) dir = 16'($urandom());
      rd = NP'($urandom_range(0, 5) == 0 ? $urandom() : 0);
      step(1);
    end
    rd = '0;
    step(SS + 2);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule